// File: doc/BRIEF.md
# Confidence-Gated Last-Value Result Predictor

This block guesses the result of an instruction before it executes by returning the value that the same instruction address produced the last time it ran. It keeps two tables, and both are indexed by the instruction address. A value table holds a tag and the last result for each entry. A smaller classification table holds a 2-bit confidence counter, and that counter decides whether the guess is worth using.

A front-end stage presents an address on the lookup port. One cycle later the block returns the stored value, a hit flag and a use flag. When the instruction finishes, the back end sends the address, the computed result, the value it was given and the hit flag it saw. The block then allocates a new entry, strengthens or weakens the confidence, or replaces the stored value.

The strongest confidence state does two things. It allows prediction, and it protects the stored value, so a single wrong outcome lowers the confidence but leaves the value in place.

Top module: `vp_top`

## Requirements
- R1: After reset every lookup returns hit = 0 and use = 0 until an update has allocated the matching entry.
- R2: An update with upd_hit = 0 allocates the entry. It writes the tag and the computed result and sets the confidence to 1, so the next lookup returns hit = 1, use = 0 and the new value.
- R3: An update with upd_hit = 1 where upd_result differs from upd_pred and the confidence is 0, 1 or 2 replaces the stored value with upd_result.
- R4: An update with upd_hit = 1 counts as correct when upd_result equals upd_pred. A correct update raises the confidence by one and holds it at 3. A wrong update lowers it by one and holds it at 0.
- R5: use = 1 exactly when hit = 1 and the confidence is 2 or 3. Values 0 and 1 keep use at 0.
- R6: A wrong update at confidence 3 keeps the stored value and lowers the confidence to 2.
- R7: The value-table index is pc[2 +: log2(VT_DEPTH)] and the tag is the bits above it. pc[1:0] is ignored. A tag mismatch gives hit = 0 and use = 0 whatever the confidence.
- R8: The classification table is indexed by pc[2 +: log2(CT_DEPTH)] on its own. Addresses with equal low bits share one counter, even when their value entries differ.
- R9: Lookup outputs appear in the cycle after the address is presented. An update in the same cycle as a lookup to the same entry is not seen by that lookup, but it is seen by the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Lookup instruction address |
| lk_hit | output | 1 | Entry valid and tag matches (one cycle after lk_pc) |
| lk_use | output | 1 | Prediction is trusted |
| lk_value | output | VAL_W | Stored last result |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | PC_W | Address of the finished instruction |
| upd_hit | input | 1 | Hit flag seen at lookup, carried back |
| upd_pred | input | VAL_W | Value returned at lookup, carried back |
| upd_result | input | VAL_W | Computed result |

## Verification
The bench builds the block with 16 value entries, 8 classification entries and a 16-bit address. At that size, two addresses 0x40 bytes apart collide in the value table with different tags. Two addresses 0x20 bytes apart share a counter while they occupy different value entries. This lets a handful of directed addresses reach tag replacement, counter aliasing and the lock behaviour at the top confidence state, and the full counter walk fits in a few dozen cycles.

// File: rtl/vp_pkg.sv
package vp_pkg;
    typedef logic [1:0] conf_t;

    localparam conf_t CONF_MIN  = 2'd0;
    localparam conf_t CONF_INIT = 2'd1;
    localparam conf_t CONF_USE  = 2'd2;
    localparam conf_t CONF_MAX  = 2'd3;

    function automatic conf_t conf_up(conf_t c);
        return (c == CONF_MAX) ? CONF_MAX : conf_t'(c + 2'd1);
    endfunction

    function automatic conf_t conf_down(conf_t c);
        return (c == CONF_MIN) ? CONF_MIN : conf_t'(c - 2'd1);
    endfunction
endpackage

// File: rtl/vp_value_table.sv
module vp_value_table #(
    parameter int DEPTH = 4096,
    parameter int TAG_W = 18,
    parameter int VAL_W = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [VAL_W-1:0] rd_val,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [VAL_W-1:0] wr_val
);
    logic [DEPTH-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [VAL_W-1:0] val_mem [DEPTH];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            val_mem[wr_idx] <= wr_val;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_val   = val_mem[rd_idx];
endmodule

// File: rtl/vp_conf_table.sv
module vp_conf_table
    import vp_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output conf_t         rd_ctr,
    input  logic [IW-1:0] cur_idx,
    output conf_t         cur_ctr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  conf_t         wr_ctr
);
    conf_t ctr_d [DEPTH];
    conf_t ctr_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ctr_d[i] = ctr_q[i];
        if (wr_en) ctr_d[wr_idx] = wr_ctr;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) ctr_q[i] <= CONF_MIN;
            else        ctr_q[i] <= ctr_d[i];
        end
    end

    assign rd_ctr  = ctr_q[rd_idx];
    assign cur_ctr = ctr_q[cur_idx];
endmodule

// File: rtl/vp_update_ctl.sv
module vp_update_ctl
    import vp_pkg::*;
#(
    parameter int VAL_W = 64
) (
    input  logic             upd_valid,
    input  logic             upd_hit,
    input  logic [VAL_W-1:0] upd_pred,
    input  logic [VAL_W-1:0] upd_result,
    input  conf_t            cur_ctr,
    output logic             vt_wr_en,
    output logic             ct_wr_en,
    output conf_t            ct_wr_ctr
);
    logic agree;
    assign agree = (upd_pred == upd_result);

    always_comb begin
        vt_wr_en  = 1'b0;
        ct_wr_en  = 1'b0;
        ct_wr_ctr = cur_ctr;
        if (upd_valid) begin
            ct_wr_en = 1'b1;
            if (!upd_hit) begin
                vt_wr_en  = 1'b1;
                ct_wr_ctr = CONF_INIT;
            end else if (agree) begin
                ct_wr_ctr = conf_up(cur_ctr);
            end else begin
                ct_wr_ctr = conf_down(cur_ctr);
                vt_wr_en  = (cur_ctr != CONF_MAX);
            end
        end
    end
endmodule

// File: rtl/vp_top.sv
module vp_top
    import vp_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int VAL_W    = 64,
    parameter int VT_DEPTH = 4096,
    parameter int CT_DEPTH = 1024,
    localparam int VT_IW   = $clog2(VT_DEPTH),
    localparam int CT_IW   = $clog2(CT_DEPTH),
    localparam int TAG_W   = PC_W - 2 - VT_IW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic             lk_use,
    output logic [VAL_W-1:0] lk_value,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_hit,
    input  logic [VAL_W-1:0] upd_pred,
    input  logic [VAL_W-1:0] upd_result
);
    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] want;
        logic [VAL_W-1:0] val;
        conf_t            ctr;
    } rd_t;

    rd_t rd_d, rd_q;

    logic             vt_rd_valid;
    logic [TAG_W-1:0] vt_rd_tag;
    logic [VAL_W-1:0] vt_rd_val;
    conf_t            ct_rd_ctr;
    conf_t            cur_ctr;
    logic             vt_wr_en;
    logic             ct_wr_en;
    conf_t            ct_wr_ctr;
    logic             unused_offset;

    assign unused_offset = ^{lk_pc[1:0], upd_pc[1:0]};

    vp_value_table #(.DEPTH(VT_DEPTH), .TAG_W(TAG_W), .VAL_W(VAL_W)) vt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_pc[2 +: VT_IW]),
        .rd_valid (vt_rd_valid),
        .rd_tag   (vt_rd_tag),
        .rd_val   (vt_rd_val),
        .wr_en    (vt_wr_en),
        .wr_idx   (upd_pc[2 +: VT_IW]),
        .wr_tag   (upd_pc[PC_W-1 -: TAG_W]),
        .wr_val   (upd_result)
    );

    vp_conf_table #(.DEPTH(CT_DEPTH)) ct_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_pc[2 +: CT_IW]),
        .rd_ctr  (ct_rd_ctr),
        .cur_idx (upd_pc[2 +: CT_IW]),
        .cur_ctr (cur_ctr),
        .wr_en   (ct_wr_en),
        .wr_idx  (upd_pc[2 +: CT_IW]),
        .wr_ctr  (ct_wr_ctr)
    );

    vp_update_ctl #(.VAL_W(VAL_W)) ctl_i (
        .upd_valid  (upd_valid),
        .upd_hit    (upd_hit),
        .upd_pred   (upd_pred),
        .upd_result (upd_result),
        .cur_ctr    (cur_ctr),
        .vt_wr_en   (vt_wr_en),
        .ct_wr_en   (ct_wr_en),
        .ct_wr_ctr  (ct_wr_ctr)
    );

    always_comb begin
        rd_d.valid = vt_rd_valid;
        rd_d.tag   = vt_rd_tag;
        rd_d.want  = lk_pc[PC_W-1 -: TAG_W];
        rd_d.val   = vt_rd_val;
        rd_d.ctr   = ct_rd_ctr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign lk_hit   = rd_q.valid && (rd_q.tag == rd_q.want);
    assign lk_use   = lk_hit && (rd_q.ctr >= CONF_USE);
    assign lk_value = rd_q.val;
endmodule

// File: rtl/vp_checker.sv
module vp_checker
    import vp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int VAL_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_hit,
    input logic             lk_use,
    input logic [VAL_W-1:0] lk_value,
    input logic             upd_valid,
    input logic             upd_hit,
    input logic [VAL_W-1:0] upd_pred,
    input logic [VAL_W-1:0] upd_result,
    input conf_t            cur_ctr,
    input logic             vt_wr_en,
    input logic             ct_wr_en,
    input conf_t            ct_wr_ctr
);
    logic right;
    assign right = upd_hit && (upd_pred == upd_result);

    assert_use_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_use |-> lk_hit);

    assert_alloc_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_hit) |-> (vt_wr_en && ct_wr_en && ct_wr_ctr == CONF_INIT));

    assert_top_locks_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_hit && !right && cur_ctr == CONF_MAX)
            |-> (!vt_wr_en && ct_wr_ctr == CONF_USE));

    assert_correct_keeps_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && right) |-> (!vt_wr_en && ct_wr_ctr >= cur_ctr));

    assert_idle_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> (!vt_wr_en && !ct_wr_en));

    assert_stable_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_pc == $past(lk_pc) && !$past(upd_valid))
            |=> ($stable(lk_value) && $stable(lk_hit) && $stable(lk_use)));
endmodule

bind vp_top vp_checker #(.PC_W(PC_W), .VAL_W(VAL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_pc      (lk_pc),
    .lk_hit     (lk_hit),
    .lk_use     (lk_use),
    .lk_value   (lk_value),
    .upd_valid  (upd_valid),
    .upd_hit    (upd_hit),
    .upd_pred   (upd_pred),
    .upd_result (upd_result),
    .cur_ctr    (cur_ctr),
    .vt_wr_en   (vt_wr_en),
    .ct_wr_en   (ct_wr_en),
    .ct_wr_ctr  (ct_wr_ctr)
);

// File: tb/vp_top_tb_top.sv
module vp_top_tb_top;
    localparam int PC_W = 16;
    localparam int VAL_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  lk_pc = '0;
    logic             lk_hit, lk_use;
    logic [VAL_W-1:0] lk_value;
    logic             upd_valid = 1'b0;
    logic [PC_W-1:0]  upd_pc = '0;
    logic             upd_hit = 1'b0;
    logic [VAL_W-1:0] upd_pred = '0;
    logic [VAL_W-1:0] upd_result = '0;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [PC_W-1:0] PA = 16'h0104;
    localparam logic [PC_W-1:0] PB = 16'h0144;
    localparam logic [PC_W-1:0] PC = 16'h0124;
    localparam logic [PC_W-1:0] PD = 16'h0208;
    localparam logic [VAL_W-1:0] V1 = 64'h1111_2222_3333_4444;
    localparam logic [VAL_W-1:0] V2 = 64'hA5A5_0000_FFFF_0001;
    localparam logic [VAL_W-1:0] V3 = 64'h0000_0000_0000_0003;
    localparam logic [VAL_W-1:0] V4 = 64'h8000_0000_0000_0000;
    localparam logic [VAL_W-1:0] VB = 64'h0BB0_0BB0_0BB0_0BB0;
    localparam logic [VAL_W-1:0] VC = 64'hCCCC_0000_0000_CCCC;
    localparam logic [VAL_W-1:0] VD = 64'hDDDD_1234_5678_DDDD;

    always #5 clk = ~clk;

    vp_top #(.PC_W(PC_W), .VAL_W(VAL_W), .VT_DEPTH(16), .CT_DEPTH(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_pc      (lk_pc),
        .lk_hit     (lk_hit),
        .lk_use     (lk_use),
        .lk_value   (lk_value),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_hit    (upd_hit),
        .upd_pred   (upd_pred),
        .upd_result (upd_result)
    );

    task automatic check(input string tag, input logic [VAL_W-1:0] act, input logic [VAL_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [PC_W-1:0] pc);
        @(negedge clk) lk_pc = pc;
        @(negedge clk);
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input logic [VAL_W-1:0] res,
                       input logic [VAL_W-1:0] pred, input logic hit);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_result = res; upd_pred = pred; upd_hit = hit;
        @(negedge clk) upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        look(PA);
        check("R1 hit after reset", 64'(lk_hit), 64'd0);
        check("R1 use after reset", 64'(lk_use), 64'd0);
    endtask

    task automatic t_alloc();
        upd(PA, V1, '0, 1'b0);
        look(PA);
        check("R2 hit after alloc", 64'(lk_hit), 64'd1);
        check("R2 use after alloc", 64'(lk_use), 64'd0);
        check("R2 value after alloc", lk_value, V1);
    endtask

    task automatic t_confidence();
        upd(PA, V1, V1, 1'b1);                       // 1 -> 2
        look(PA);
        check("R5 use at conf 2", 64'(lk_use), 64'd1);
        upd(PA, V1, V1, 1'b1);                       // 2 -> 3
        upd(PA, V1, V1, 1'b1);                       // stays 3
        upd(PA, V2, V1, 1'b1);                       // wrong at 3 -> 2, value kept
        look(PA);
        check("R6 value locked at conf 3", lk_value, V1);
        check("R4 saturate high then one drop", 64'(lk_use), 64'd1);
        upd(PA, V2, V1, 1'b1);                       // wrong at 2 -> 1, replaced
        look(PA);
        check("R3 value replaced", lk_value, V2);
        check("R5 use at conf 1", 64'(lk_use), 64'd0);
        upd(PA, V3, V2, 1'b1);                       // 1 -> 0
        upd(PA, V4, V3, 1'b1);                       // stays 0
        look(PA);
        check("R3 value replaced at conf 0", lk_value, V4);
        upd(PA, V4, V4, 1'b1);                       // 0 -> 1
        look(PA);
        check("R4 saturate low", 64'(lk_use), 64'd0);
        upd(PA, V4, V4, 1'b1);                       // 1 -> 2
        look(PA);
        check("R4 climb to use", 64'(lk_use), 64'd1);
    endtask

    task automatic t_tag();
        look(PB);
        check("R7 tag mismatch hit", 64'(lk_hit), 64'd0);
        check("R7 tag mismatch use", 64'(lk_use), 64'd0);
        upd(PB, VB, '0, 1'b0);
        look(PA);
        check("R7 evicted tag misses", 64'(lk_hit), 64'd0);
        look(PB);
        check("R7 new tag hits", 64'(lk_hit), 64'd1);
        check("R7 new tag value", lk_value, VB);
    endtask

    task automatic t_alias();
        upd(PB, VB, VB, 1'b1);                       // shared counter 1 -> 2
        look(PB);
        check("R8 use before alias", 64'(lk_use), 64'd1);
        upd(PC, VC, '0, 1'b0);                       // shared counter reset to 1
        look(PB);
        check("R8 other entry still hits", 64'(lk_hit), 64'd1);
        check("R8 shared counter drops use", 64'(lk_use), 64'd0);
        look(PC);
        check("R8 aliased value", lk_value, VC);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        lk_pc = PD;
        upd_valid = 1'b1; upd_pc = PD; upd_result = VD; upd_pred = '0; upd_hit = 1'b0;
        @(negedge clk) upd_valid = 1'b0;
        check("R9 concurrent lookup misses", 64'(lk_hit), 64'd0);
        @(negedge clk);
        check("R9 next lookup hits", 64'(lk_hit), 64'd1);
        check("R9 next lookup value", lk_value, VD);
        look(PD | 16'h0003);
        check("R7 offset bits ignored", 64'(lk_hit), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alloc();
        t_confidence();
        t_tag();
        t_alias();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule